// File: doc/BRIEF.md
# Dual-Order Four-Beat Burst Address Sequencer

This block produces the word address for every access of a four-beat burst. When either of two active-low address strobes is seen at a clock edge, it captures the whole external address as the burst base and restarts its beat count at zero. On each later cycle, the active-low advance input either steps the burst to the next beat or holds the current address, which suspends the burst. The upper address bits always come straight from the captured base. Only the low two bits move.

The order of the low bits is set by a static mode input. A low level selects linear order, which counts up modulo four from the loaded value. A high level selects interleaved order, which XORs the loaded low bits with the beat count. Interleaved is the intended default, so a board-level tie-high gives that mode. Both orders return to the loaded start after four steps. A read whose data is later discarded steps the sequencer in exactly the same way as a normal read, because the sequencer only ever sees the advance input.

Control runs in a small state machine with three states:
- `ST_IDLE`: no base has been captured since reset.
- `ST_RUN`: the last cycle loaded or stepped.
- `ST_PAUSE`: the last cycle held.

It moves between them through four named transitions:
- T_LOAD: any state goes to `ST_RUN` when a strobe is seen.
- T_STEP: `ST_RUN` or `ST_PAUSE` goes to `ST_RUN` when advance is low and there is no strobe.
- T_STALL: `ST_RUN` or `ST_PAUSE` goes to `ST_PAUSE` when advance is high and there is no strobe.
- T_WAIT: `ST_IDLE` stays in `ST_IDLE` when there is no strobe.

Top module: `burst_seq`

## Requirements
- R1: After reset, `cur_addr` is all zeros.
- R2: A low level on either `strobe_a_n` or `strobe_b_n` at a rising edge loads the full `ext_addr`, and `cur_addr` equals it after that edge.
- R3: A strobe takes priority over `adv_n`: a cycle with both a strobe and `adv_n` low yields exactly the new `ext_addr`, with the beat count back at zero.
- R4: With `order_mode` = 0 (linear), the low two bits after k steps equal (loaded low bits + k) mod 4. For example, a start of 01 gives 01, 10, 11, 00.
- R5: With `order_mode` = 1 (interleaved), the low two bits after k steps equal (loaded low bits XOR k). For example, a start of 01 gives 01, 00, 11, 10.
- R6: The fourth step after a load returns `cur_addr` to the loaded address, in both orders.
- R7: A cycle with `adv_n` high and no strobe leaves `cur_addr` unchanged.
- R8: Bits above the low two of `cur_addr` equal the loaded `ext_addr` bits throughout a burst.
- R9: Before the first strobe after reset, `adv_n` low has no effect, and `cur_addr` stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_a_n | input | 1 | First address strobe, active low |
| strobe_b_n | input | 1 | Second address strobe, active low |
| adv_n | input | 1 | Burst advance enable, active low |
| order_mode | input | 1 | 0 = linear order, 1 = interleaved order |
| ext_addr | input | ADDR_W | External address captured on a strobe |
| cur_addr | output | ADDR_W | Address of the current beat |

## Verification
The state of this block lives in three places: the base register, the beat counter and the control state. Each one is visible on `cur_addr` one clock after it goes wrong.
- A corrupted base shows up at once in the upper bits, or in the start point of the burst.
- A beat counter that skips, sticks or fails to clear on a strobe puts the wrong low bits on the very next beat.
- A lost suspend shows as movement during a held cycle.
- A control state that leaves `ST_IDLE` without a strobe lets the address move before any load.

The directed scenarios walk full bursts in both orders and with both strobes. They compare every beat, including the wrap beat, against a sequence computed from the start value.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_PAUSE = 2'd2
    } seq_state_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_t;

endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
    import bseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_req,
    input  logic       adv_n,
    output logic       load_en,
    output logic       step_en,
    output seq_state_t state_o
);

    seq_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state: T_LOAD, T_STEP, T_STALL, T_WAIT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load_req) state_d = ST_RUN;      // T_LOAD
                else          state_d = ST_IDLE;     // T_WAIT
            end
            ST_RUN, ST_PAUSE: begin
                if (load_req)    state_d = ST_RUN;   // T_LOAD
                else if (!adv_n) state_d = ST_RUN;   // T_STEP
                else             state_d = ST_PAUSE; // T_STALL
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        load_en = 1'b0;
        step_en = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load_en = load_req;
            end
            ST_RUN, ST_PAUSE: begin
                load_en = load_req;
                step_en = !load_req && !adv_n;
            end
            default: begin
                load_en = 1'b0;
                step_en = 1'b0;
            end
        endcase
    end

    assign state_o = state_q;

    // R9: the state machine leaves idle only through a strobe
    a_r9_idle_exit_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !load_req) |=> (state_q == ST_IDLE));

    // R7: a held cycle lands in the pause state
    a_r7_stall_pauses: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !load_req && adv_n) |=> (state_q == ST_PAUSE));

endmodule

// File: rtl/bseq_beat.sv
module bseq_beat #(
    parameter int BURST_BITS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_en,
    input  logic                  step_en,
    output logic [BURST_BITS-1:0] beat_o
);

    logic [BURST_BITS-1:0] beat_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       beat_q <= '0;
        else if (load_en) beat_q <= '0;
        else if (step_en) beat_q <= beat_q + 1'b1;
    end

    assign beat_o = beat_q;

    // R3: a load restarts the beat count
    a_r3_load_clears_beat: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (beat_o == '0));

    // R4 and R5: a step moves exactly one beat, wrapping modulo the burst length
    a_r4_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load_en) |=> (beat_o == BURST_BITS'($past(beat_o) + 1'b1)));

    // R7: no load and no step means the beat is held
    a_r7_beat_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !load_en) |=> $stable(beat_o));

endmodule

// File: rtl/bseq_addr.sv
module bseq_addr
    import bseq_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int BURST_BITS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_en,
    input  order_t                order,
    input  logic [ADDR_W-1:0]     ext_addr,
    input  logic [BURST_BITS-1:0] beat,
    output logic [ADDR_W-1:0]     addr_o
);

    localparam int HI_W = ADDR_W - BURST_BITS;

    logic [ADDR_W-1:0]     base_q;
    logic [BURST_BITS-1:0] low_lin, low_int, low_sel;

    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= '0;
        else if (load_en) base_q <= ext_addr;
    end

    assign low_lin = base_q[BURST_BITS-1:0] + beat;
    assign low_int = base_q[BURST_BITS-1:0] ^ beat;

    always_comb begin
        unique case (order)
            ORD_LINEAR:     low_sel = low_lin;
            ORD_INTERLEAVE: low_sel = low_int;
            default:        low_sel = low_int;
        endcase
    end

    assign addr_o = {base_q[ADDR_W-1:BURST_BITS], low_sel};

    // R2: a load captures the full external address
    a_r2_base_capture: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (base_q == $past(ext_addr)));

    // R8: the base holds between loads
    a_r8_base_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(base_q));

    initial begin
        a_r8_width_ok: assert (HI_W > 0);
    end

endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int BURST_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_a_n,
    input  logic              strobe_b_n,
    input  logic              adv_n,
    input  logic              order_mode,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] cur_addr
);

    logic                  load_req;
    logic                  load_en;
    logic                  step_en;
    logic [BURST_BITS-1:0] beat;
    seq_state_t            state;

    assign load_req = !strobe_a_n || !strobe_b_n;

    bseq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_req (load_req),
        .adv_n    (adv_n),
        .load_en  (load_en),
        .step_en  (step_en),
        .state_o  (state)
    );

    bseq_beat #(.BURST_BITS(BURST_BITS)) u_beat (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .step_en (step_en),
        .beat_o  (beat)
    );

    bseq_addr #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .order    (order_t'(order_mode)),
        .ext_addr (ext_addr),
        .beat     (beat),
        .addr_o   (cur_addr)
    );

    // R2 and R3: any strobe puts the external address on the output next cycle
    a_r2_strobe_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && $stable(order_mode)) |=> (cur_addr == $past(ext_addr)));

    // R9: while idle the output stays at the reset value
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !load_req) |=> (cur_addr == '0));

    // R8: the upper bits only change on a strobe
    a_r8_upper_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !load_req |=> $stable(cur_addr[ADDR_W-1:BURST_BITS]));

endmodule

// File: tb/sim_burst_seq.sv
module sim_burst_seq;

    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sa_n = 1'b1;
    logic          sb_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          mode = 1'b1;
    logic [AW-1:0] ext_addr = '0;
    logic [AW-1:0] cur_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    burst_seq #(.ADDR_W(AW), .BURST_BITS(2)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_a_n (sa_n),
        .strobe_b_n (sb_n),
        .adv_n      (adv_n),
        .order_mode (mode),
        .ext_addr   (ext_addr),
        .cur_addr   (cur_addr)
    );

    function automatic logic [AW-1:0] expect_addr(logic [AW-1:0] start, int k, logic m);
        logic [1:0] lo;
        if (m) lo = start[1:0] ^ 2'(k);
        else   lo = 2'(int'(start[1:0]) + k);
        return {start[AW-1:2], lo};
    endfunction

    task automatic chk(string req, logic [AW-1:0] got, logic [AW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
    task automatic cyc(logic a_n, logic b_n, logic av_n, logic [AW-1:0] addr);
        sa_n = a_n; sb_n = b_n; adv_n = av_n; ext_addr = addr;
        @(negedge clk);
        sa_n = 1'b1; sb_n = 1'b1; adv_n = 1'b1;
    endtask

    task automatic t_reset();
        chk("R1 reset value", cur_addr, '0);
    endtask

    task automatic t_idle_adv();
        for (int i = 0; i < 3; i++) begin
            cyc(1'b1, 1'b1, 1'b0, 12'hFFF);
            chk("R9 advance before load", cur_addr, '0);
        end
    endtask

    task automatic t_burst(logic m, logic use_a, logic [AW-1:0] start, string rq);
        mode = m;
        cyc(!use_a, use_a, 1'b1, start);
        chk("R2 load", cur_addr, start);
        for (int k = 1; k <= 4; k++) begin
            cyc(1'b1, 1'b1, 1'b0, ~start);
            chk(rq, cur_addr, expect_addr(start, k, m));
            chk("R8 upper bits", {cur_addr[AW-1:2], 2'b00}, {start[AW-1:2], 2'b00});
        end
        chk("R6 wrap to start", cur_addr, start);
    endtask

    task automatic t_suspend();
        logic [AW-1:0] st = 12'h5A3;
        mode = 1'b0;
        cyc(1'b0, 1'b1, 1'b1, st);
        cyc(1'b1, 1'b1, 1'b0, '0);
        chk("R4 first step", cur_addr, expect_addr(st, 1, 1'b0));
        for (int i = 0; i < 2; i++) begin
            cyc(1'b1, 1'b1, 1'b1, 12'h000);
            chk("R7 hold", cur_addr, expect_addr(st, 1, 1'b0));
        end
        cyc(1'b1, 1'b1, 1'b0, '0);
        chk("R7 resume after hold", cur_addr, expect_addr(st, 2, 1'b0));
    endtask

    task automatic t_priority();
        logic [AW-1:0] nw = 12'h8C2;
        mode = 1'b1;
        cyc(1'b0, 1'b1, 1'b1, 12'h111);
        cyc(1'b1, 1'b1, 1'b0, '0);
        cyc(1'b1, 1'b0, 1'b0, nw);
        chk("R3 strobe wins over advance", cur_addr, nw);
        cyc(1'b1, 1'b1, 1'b0, '0);
        chk("R3 beat restarted", cur_addr, expect_addr(nw, 1, 1'b1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_adv();
        t_burst(1'b0, 1'b1, 12'hA51, "R4 linear step");
        t_burst(1'b1, 1'b0, 12'h3C6, "R5 interleaved step");
        t_burst(1'b1, 1'b1, 12'h7F1, "R5 interleaved from 01");
        t_burst(1'b0, 1'b0, 12'h0E3, "R4 linear from 11");
        t_suspend();
        t_priority();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule